// File: doc/BRIEF.md
# Prescaled Reloading Interval Timer

This block is a programmable interval timer for a processor core. The host writes three registers over a simple write-only register port. The first is a start count, which also becomes the reload period. The second is a control word that sets the run state, repeat mode and a power-of-two prescale divisor. The third holds an interrupt-enable flag. While the timer runs, every prescaled tick lowers the live count by one. The tick that takes the count from one to zero raises an interrupt request.

In repeat mode, the tick that finds the count at zero reloads it from the period register, and counting carries on without any host action. In one-shot mode, the timer clears its own run bit on the tick that reaches zero. Once raised, the request stays asserted until the host acknowledge shows a rising edge. A second expiry that comes during service is therefore not lost. Because of the prescaler, a 16-bit count can still span a very long interval.

Top module: `prescaled_interval_timer`

## Requirements
- R1: After reset, irq_o is 0, count_o is 0 and running_o is 0.
- R2: A write to address 0 loads bits 15:0 into the live counter and into the period register. count_o shows the value after the write edge, and the write takes precedence over a tick in the same cycle.
- R3: A write to address 1 sets the control word. Bit 5 is run, bit 4 is repeat and bits 3:0 are a select s that gives a prescale divisor D = 2^(s+1), so D ranges from 2 to 65536. running_o mirrors the run bit.
- R4: When a control write sets run while run is clear, the first decrement lands on the clock edge 3 + D edges after the write edge. Later decrements follow every D edges, and each step changes count_o by exactly one.
- R5: If bit 8 of the register at address 2 is set, irq_o rises on the same edge where count_o goes from 1 to 0.
- R6: A start count of 0 never raises irq_o.
- R7: With repeat set, the tick that finds the count at 0 reloads the period, and counting continues with no further write.
- R8: With repeat clear, the tick that reaches 0 also clears run. count_o then stays at 0.
- R9: Clearing run freezes count_o and resets the prescaler. A later start pays the full latency of R4 again.
- R10: Once raised, irq_o stays high until a rising edge of irq_ack_i. An acknowledge that is held high does not clear a later request.
- R11: If bit 8 of the address-2 register is clear, no expiry raises irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 count, 1 control, 2 interrupt enable |
| wr_data_i | input | 16 | Write data |
| irq_ack_i | input | 1 | Interrupt acknowledge; its rising edge clears the request |
| irq_o | output | 1 | Interrupt request, held until acknowledged |
| count_o | output | 16 | Live counter value |
| running_o | output | 1 | Current run bit |

## Verification
Every result is due a fixed number of edges after the write edge that starts it. count_o and running_o change right after a write. The first decrement comes 3 + D edges after the control write that sets run, and each later step comes D edges after the one before. irq_o rises on the same edge as the step to zero, and it falls on the edge that samples a new acknowledge high. The bench drives inputs and samples outputs on falling clock edges. It counts edges from the write edge of each start, so every check lands in the half-cycle after the edge that owes the result. The vector table covers divisors from 2 to 65536, and each vector measures the exact edge on which irq_o rises.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int SEL_W = 4;

  typedef enum logic [1:0] {
    REG_COUNT = 2'd0,
    REG_CTRL  = 2'd1,
    REG_IEN   = 2'd2
  } reg_sel_e;

  // bit 5 run, bit 4 repeat, bits 3:0 divisor select
  typedef struct packed {
    logic             run;
    logic             rpt;
    logic [SEL_W-1:0] div_sel;
  } ctrl_t;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int SEL_W      = 4,
  parameter int ARM_CYCLES = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] div_sel_i,
  output logic             tick_o
);
  localparam int PRE_W = 1 << SEL_W;

  logic             en;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] term;

  generate
    if (ARM_CYCLES > 0) begin : g_arm
      logic [ARM_CYCLES-1:0] arm_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     arm_q <= '0;
        else if (!run_i) arm_q <= '0;
        else             arm_q <= (arm_q << 1) | ARM_CYCLES'(1);
      end
      assign en = run_i & arm_q[ARM_CYCLES-1];
    end else begin : g_no_arm
      assign en = run_i;
    end
  endgenerate

  // terminal count = 2^(sel+1) - 1
  always_comb begin
    for (int i = 0; i < PRE_W; i++) term[i] = (i <= int'(div_sel_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            pre_q <= '0;
    else if (!en)           pre_q <= '0;
    else if (pre_q == term) pre_q <= '0;
    else                    pre_q <= pre_q + 1'b1;
  end

  assign tick_o = en && (pre_q == term);
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  input  logic             rpt_i,
  output logic [CNT_W-1:0] count_o,
  output logic             zero_evt_o,
  output logic             stop_o
);
  logic [CNT_W-1:0] cnt_q, per_q;
  logic             at_zero, at_one, step;

  assign at_zero = (cnt_q == '0);
  assign at_one  = (cnt_q == CNT_W'(1));
  assign step    = tick_i & ~load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      per_q <= load_val_i;
    end else if (tick_i) begin
      if (at_zero) begin
        if (rpt_i) cnt_q <= per_q;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign zero_evt_o = step & at_one;
  assign stop_o     = step & ~rpt_i & (at_one | at_zero);
  assign count_o    = cnt_q;
endmodule

// File: rtl/pit_irq.sv
module pit_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic ien_i,
  input  logic ack_i,
  output logic irq_o
);
  logic ack_q, irq_q, ack_rise;

  assign ack_rise = ack_i & ~ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ack_q <= ack_i;
      // a new expiry wins over a coincident acknowledge
      irq_q <= (evt_i & ien_i) | (irq_q & ~ack_rise);
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/prescaled_interval_timer.sv
module prescaled_interval_timer
  import pit_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 16,
  parameter int IEN_BIT    = 8,
  parameter int ARM_CYCLES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              irq_ack_i,
  output logic              irq_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              running_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t    ctrl_q;
  logic     ien_q;
  reg_sel_e sel;
  logic     wr_cnt, wr_ctrl, wr_ien;
  logic     tick, zero_evt, stop;

  assign sel     = reg_sel_e'(wr_addr_i);
  assign wr_cnt  = wr_en_i && (sel == REG_COUNT);
  assign wr_ctrl = wr_en_i && (sel == REG_CTRL);
  assign wr_ien  = wr_en_i && (sel == REG_IEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ien_q  <= 1'b0;
    end else begin
      if (wr_ctrl)   ctrl_q     <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
      else if (stop) ctrl_q.run <= 1'b0;
      if (wr_ien)    ien_q      <= wr_data_i[IEN_BIT];
    end
  end

  pit_prescaler #(
    .SEL_W     (SEL_W),
    .ARM_CYCLES(ARM_CYCLES)
  ) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (ctrl_q.run),
    .div_sel_i(ctrl_q.div_sel),
    .tick_o   (tick)
  );

  pit_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (wr_cnt),
    .load_val_i(wr_data_i[CNT_W-1:0]),
    .tick_i    (tick),
    .rpt_i     (ctrl_q.rpt),
    .count_o   (count_o),
    .zero_evt_o(zero_evt),
    .stop_o    (stop)
  );

  pit_irq u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (zero_evt),
    .ien_i (ien_q),
    .ack_i (irq_ack_i),
    .irq_o (irq_o)
  );

  assign running_o = ctrl_q.run;
endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             irq_ack_i,
  input logic             irq_o,
  input logic [CNT_W-1:0] count_o,
  input logic             running_o
);
  logic ack_prev, ack_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_prev <= 1'b0;
    else         ack_prev <= irq_ack_i;
  end
  assign ack_rise = irq_ack_i & ~ack_prev;

  a_r5_irq_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (count_o == '0));

  a_r4_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && count_o != '0) |=>
      (count_o == $past(count_o) || count_o == $past(count_o) - CNT_W'(1)));

  a_r9_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_o && !wr_en_i) |=> $stable(count_o));

  a_r8_stop_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(running_o) && !$past(wr_en_i)) |-> (count_o == '0));

  a_r10_hold_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack_rise) |=> irq_o);
endmodule

bind prescaled_interval_timer pit_checker #(.CNT_W(CNT_W)) u_pit_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .irq_ack_i(irq_ack_i),
  .irq_o    (irq_o),
  .count_o  (count_o),
  .running_o(running_o)
);

// File: tb/tb_prescaled_interval_timer.sv
`timescale 1ns/1ps
module tb_prescaled_interval_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        ack = 1'b0;
  logic        irq;
  logic [15:0] count;
  logic        running;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  prescaled_interval_timer dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .irq_ack_i(ack),
    .irq_o    (irq),
    .count_o  (count),
    .running_o(running)
  );

  // {start count, control word, edge of irq rise after control write}
  localparam int NV = 6;
  localparam int VEC [NV][3] = '{
    '{2, 'h30, 7},
    '{1, 'h30, 5},
    '{3, 'h31, 15},
    '{5, 'h32, 43},
    '{1, 'h33, 19},
    '{1, 'h3F, 65539}
  };

  task automatic check(string req, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // call at a negedge; write lands on the next posedge; returns at the following negedge
  task automatic wr_reg(logic [1:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clean();
    wr_reg(2'd1, 16'h0000);
    ack = 1'b1; @(negedge clk);
    ack = 1'b0; @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    if (!done) $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int t;
    rst_n = 1'b0;
    wait_n(3);
    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 count", count, 0);
    check("R1 running", running, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 R5 table over divisors
    for (int v = 0; v < NV; v++) begin
      clean();
      wr_reg(2'd2, 16'h0100);
      wr_reg(2'd0, 16'(VEC[v][0]));
      wr_reg(2'd1, 16'(VEC[v][1]));
      check("R3 running", running, 1);
      t = 0;
      while (!irq && t < 70000) begin
        @(negedge clk);
        t++;
      end
      check("R4 R5 irq edge", t, VEC[v][2]);
      check("R5 count at irq", count, 0);
    end

    // R2 load and precedence, max count, first step latency
    clean();
    wr_reg(2'd0, 16'hFFFF);
    check("R2 load max", count, 16'hFFFF);
    wr_reg(2'd1, 16'h0030);
    wait_n(4);
    check("R4 before first step", count, 16'hFFFF);
    wait_n(1);
    check("R4 first step", count, 16'hFFFE);
    wr_reg(2'd0, 16'd7);
    check("R2 load while running", count, 7);

    // R5 R7 R10 repeat, reload and hold
    clean();
    wr_reg(2'd2, 16'h0100);
    wr_reg(2'd0, 16'd2);
    wr_reg(2'd1, 16'h0030);
    wait_n(4);  check("R4 held start", count, 2);
    wait_n(1);  check("R4 step t5", count, 1);
    wait_n(1);  check("R4 held D", count, 1);
    check("R5 no early irq", irq, 0);
    wait_n(1);  check("R5 zero t7", count, 0);
    check("R5 irq t7", irq, 1);
    wait_n(2);  check("R7 reload t9", count, 2);
    wait_n(4);  check("R7 second zero t13", count, 0);
    check("R10 held unacked", irq, 1);
    ack = 1'b1;
    wait_n(2);  check("R10 cleared by rise t15", irq, 0);
    wait_n(4);  check("R10 new expiry t19", irq, 1);
    wait_n(2);  check("R10 held ack no clear", irq, 1);
    ack = 1'b0;
    wait_n(1);
    ack = 1'b1;
    wait_n(1);  check("R10 fresh rise clears", irq, 0);
    ack = 1'b0;

    // R8 one-shot
    clean();
    wr_reg(2'd0, 16'd2);
    wr_reg(2'd1, 16'h0020);
    wait_n(7);
    check("R8 irq", irq, 1);
    check("R8 run cleared", running, 0);
    check("R8 count zero", count, 0);
    wait_n(10);
    check("R8 stays zero", count, 0);

    // R6 zero start
    clean();
    wr_reg(2'd0, 16'd0);
    wr_reg(2'd1, 16'h0030);
    wait_n(50);
    check("R6 no irq", irq, 0);
    check("R6 count", count, 0);

    // R11 enable clear
    clean();
    wr_reg(2'd2, 16'h0000);
    wr_reg(2'd0, 16'd1);
    wr_reg(2'd1, 16'h0030);
    wait_n(5);
    check("R11 count zero", count, 0);
    check("R11 no irq", irq, 0);
    wait_n(10);
    check("R11 still no irq", irq, 0);

    // R9 freeze and full restart latency
    clean();
    wr_reg(2'd0, 16'd4);
    wr_reg(2'd1, 16'h0030);
    wait_n(5);
    check("R9 pre stop", count, 3);
    wr_reg(2'd1, 16'h0010);
    check("R9 run off", running, 0);
    wait_n(20);
    check("R9 frozen", count, 3);
    wr_reg(2'd1, 16'h0030);
    wait_n(4);
    check("R9 no early step", count, 3);
    wait_n(1);
    check("R9 restart step", count, 2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule